// File: doc/BRIEF.md
# Pause-Width Coded Command Transmitter

This block sends a short reader-to-tag command word over a single carrier-enable line. Each bit begins with a fixed carrier-off gap. The carrier then comes back on, and the bit ends when its total length reaches one of two values: a long bit stands for a coded 1 and a short bit for a coded 0. Before coding, each data bit is combined by XOR with one bit from an external keystream source. The block pulses a strobe once per bit so that the source can step to its next bit.

All timing is counted in ticks, which are qualified by a tick-enable input. With the default parameters one tick is the master clock divided by 32. The default lengths are a 30-tick gap, a 150-tick coded 1 and a 90-tick coded 0. Bits leave least significant first. After the last bit the block sends one more lone gap to close the frame. It then turns the carrier back on, restarts its internal tick timer from zero and pulses done, so that the reply window can be measured from that instant.

Top module: `pwm_frame_tx`

## Requirements
- R1: After reset, carrier_o is 1 and done_o and keystream_advance_o are 0. Outside a frame the carrier stays at 1.
- R2: Every bit starts with carrier_o at 0 for exactly GAP_TICKS ticks, counted from the bit's first cycle.
- R3: A bit whose coded value is 1 lasts ONE_TICKS ticks in total, gap included. A bit whose coded value is 0 lasts ZERO_TICKS ticks in total.
- R4: Bits leave frame_data_i least significant first, and exactly frame_len_i of them are sent.
- R5: The coded value of bit i is frame_data_i[i] XOR the keystream_bit_i present when that bit's gap begins. keystream_advance_o is high for one cycle per bit, in the cycle the carrier returns to 1 after the gap.
- R6: After the last bit the carrier goes to 0 for exactly GAP_TICKS ticks and then returns to 1.
- R7: done_o is high for a single cycle, which is the cycle the carrier returns to 1 after the closing gap. The internal tick timer restarts from zero in that cycle.
- R8: A start_i pulse that arrives while a frame is in progress has no effect. The frame in progress is sent unchanged, and no second frame follows.
- R9: A frame_len_i of zero sends only the closing gap, with no keystream advance.
- R10: A frame_len_i larger than MAX_BITS is treated as MAX_BITS.
- R11: While tick_en_i is 0, carrier_o holds its level during a frame. All durations count only the cycles in which tick_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a frame (acted on only when idle) |
| frame_data_i | input | MAX_BITS | Command bits, bit 0 sent first |
| frame_len_i | input | $clog2(MAX_BITS+1) | Number of bits to send |
| tick_en_i | input | 1 | Timing tick qualifier |
| keystream_bit_i | input | 1 | Current keystream bit |
| keystream_advance_o | output | 1 | Pulse asking the keystream source to step |
| carrier_o | output | 1 | Carrier enable, 1 = carrier on |
| done_o | output | 1 | One-cycle pulse when the frame is closed and the timer restarts |

## Verification
A wrong tick count or a wrong state shows up at once on carrier_o: a gap or a bit comes out one or more ticks too long or too short. The bench measures every carrier run length in ticks, so such an error is caught at the first bit. A wrong shift register or a wrong bit counter shows up as a frame with the wrong number of gaps, or with long and short bits in the wrong places. A keystream mix-up shows up as bit lengths that disagree with the bench's own model of the key sequence, and as advance strobes that are too many, too few or off the carrier's rising edge. Each of these is visible within the frame where it happens.

// File: rtl/pwm_tx_pkg.sv
// Shared types for the pause-width coded frame transmitter.
package pwm_tx_pkg;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,   // carrier on, waiting for a start request
        TX_GAP   = 2'd1,   // carrier off at the head of a bit
        TX_MARK  = 2'd2,   // carrier on for the rest of a bit
        TX_CLOSE = 2'd3    // lone carrier-off gap that ends the frame
    } tx_state_t;

endpackage

// File: rtl/pwm_tick_timer.sv
// Tick timer shared by all phases of a frame.
// Counts qualified ticks up from zero and saturates at its top value.
// Assumes: clear_i has priority over tick_i. The count after a clear is zero.
module pwm_tick_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    output logic [TW-1:0] count_o
);
    localparam logic [TW-1:0] TOP = {TW{1'b1}};

    // Count ticks since the last clear; saturate instead of wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (tick_i && (count_o != TOP)) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_bit_shifter.sv
// Holds the frame's data bits and the number of bits still to send.
// Shifts right by one per completed bit, so the least significant bit goes first.
// Assumes: MAX_BITS >= 2. A requested length above MAX_BITS is clamped.
module pwm_bit_shifter #(
    parameter int MAX_BITS = 32,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                shift_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [CNT_W-1:0]    len_i,
    output logic                next_bit_o,
    output logic                last_bit_o,
    output logic [CNT_W-1:0]    left_o
);
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_BITS);

    logic [MAX_BITS-1:0] sreg;
    logic [MAX_BITS-1:0] sreg_shr;
    logic [CNT_W-1:0]    len_clamped;

    // Clamp the requested length to the register size.
    always_comb begin
        len_clamped = (len_i > LEN_MAX) ? LEN_MAX : len_i;
    end

    // Next bit to send once the current one is finished.
    always_comb begin
        sreg_shr   = sreg >> 1;
        next_bit_o = sreg_shr[0];
        last_bit_o = (left_o == CNT_W'(1));
    end

    // Load a new frame, or drop one finished bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            left_o <= '0;
        end else if (load_i) begin
            sreg   <= data_i;
            left_o <= len_clamped;
        end else if (shift_i && (left_o != '0)) begin
            sreg   <= sreg_shr;
            left_o <= left_o - 1'b1;
        end
    end

    AST_LEFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        left_o <= LEN_MAX) else $error("bits left above maximum");   // R10

endmodule

// File: rtl/pwm_tx_fsm.sv
// Frame sequencer: steps through gap, mark and closing-gap phases.
// Drives the carrier, the keystream strobe, the done pulse and the timer clear.
// Assumes: the keystream source updates its bit within one cycle of a strobe.
// The timer counts qualified ticks and is cleared on clear_o.
module pwm_tx_fsm
    import pwm_tx_pkg::*;
#(
    parameter int TW         = 8,
    parameter int GAP_TICKS  = 30,
    parameter int ONE_TICKS  = 150,
    parameter int ZERO_TICKS = 90
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          len_zero_i,
    input  logic          first_bit_i,
    input  logic          next_bit_i,
    input  logic          last_bit_i,
    input  logic          tick_i,
    input  logic          ks_bit_i,
    input  logic [TW-1:0] count_i,
    output logic          carrier_o,
    output logic          advance_o,
    output logic          done_o,
    output logic          load_o,
    output logic          shift_o,
    output logic          clear_o
);
    localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_TICKS - 1);
    localparam logic [TW-1:0] ONE_LAST  = TW'(ONE_TICKS - 1);
    localparam logic [TW-1:0] ZERO_LAST = TW'(ZERO_TICKS - 1);

    tx_state_t     st;
    logic          coded;
    logic          gap_end;
    logic          mark_end;
    logic          close_end;
    logic [TW-1:0] mark_last;

    // Phase-end detection from the shared timer.
    always_comb begin
        mark_last = coded ? ONE_LAST : ZERO_LAST;
        gap_end   = tick_i && (count_i == GAP_LAST);
        mark_end  = tick_i && (count_i == mark_last) && (st == TX_MARK);
        close_end = gap_end && (st == TX_CLOSE);
    end

    // Strobes to the shifter and the timer.
    always_comb begin
        load_o  = (st == TX_IDLE) && start_i;
        shift_o = mark_end;
        clear_o = load_o || mark_end || close_end;
    end

    // State, carrier level and one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= TX_IDLE;
            carrier_o <= 1'b1;
            advance_o <= 1'b0;
            done_o    <= 1'b0;
            coded     <= 1'b0;
        end else begin
            advance_o <= 1'b0;
            done_o    <= 1'b0;
            case (st)
                TX_IDLE: begin
                    if (start_i) begin
                        carrier_o <= 1'b0;
                        if (len_zero_i) begin
                            st <= TX_CLOSE;
                        end else begin
                            st    <= TX_GAP;
                            coded <= first_bit_i ^ ks_bit_i;
                        end
                    end
                end
                TX_GAP: begin
                    if (gap_end) begin
                        carrier_o <= 1'b1;
                        advance_o <= 1'b1;
                        st        <= TX_MARK;
                    end
                end
                TX_MARK: begin
                    if (mark_end) begin
                        carrier_o <= 1'b0;
                        if (last_bit_i) begin
                            st <= TX_CLOSE;
                        end else begin
                            st    <= TX_GAP;
                            coded <= next_bit_i ^ ks_bit_i;
                        end
                    end
                end
                TX_CLOSE: begin
                    if (gap_end) begin
                        carrier_o <= 1'b1;
                        done_o    <= 1'b1;
                        st        <= TX_IDLE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    AST_GAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_o) |-> $past(count_i) == GAP_LAST) else $error("gap width wrong");   // R2

    AST_BIT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(carrier_o) && $past(st) == TX_MARK) |->
        ($past(count_i) == ONE_LAST || $past(count_i) == ZERO_LAST)) else $error("bit width wrong");   // R3

    AST_IDLE_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE) |-> carrier_o) else $error("carrier off while idle");   // R1

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && st != TX_IDLE) |=> $stable(carrier_o)) else $error("carrier moved without tick");   // R11

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> count_i == '0) else $error("timer not restarted");   // R7

endmodule

// File: rtl/pwm_frame_tx.sv
// Top of the pause-width coded frame transmitter.
// Ties the tick timer, the bit shifter and the sequencer together.
// Assumes: ONE_TICKS and ZERO_TICKS are both larger than GAP_TICKS, and MAX_BITS >= 2.
module pwm_frame_tx #(
    parameter int MAX_BITS   = 32,
    parameter int GAP_TICKS  = 30,
    parameter int ONE_TICKS  = 150,
    parameter int ZERO_TICKS = 90,
    parameter int CNT_W      = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] frame_data_i,
    input  logic [CNT_W-1:0]    frame_len_i,
    input  logic                tick_en_i,
    input  logic                keystream_bit_i,
    output logic                keystream_advance_o,
    output logic                carrier_o,
    output logic                done_o
);
    localparam int LONGEST = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
    localparam int TW      = $clog2(LONGEST + 1);

    logic          load;
    logic          shift;
    logic          clear;
    logic          next_bit;
    logic          last_bit;
    logic          len_zero;
    logic [CNT_W-1:0] left;
    logic [TW-1:0] count;

    // Zero-length request goes straight to the closing gap.
    always_comb begin
        len_zero = (frame_len_i == '0);
    end

    pwm_tick_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .tick_i  (tick_en_i),
        .count_o (count)
    );

    pwm_bit_shifter #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .shift_i    (shift),
        .data_i     (frame_data_i),
        .len_i      (frame_len_i),
        .next_bit_o (next_bit),
        .last_bit_o (last_bit),
        .left_o     (left)
    );

    pwm_tx_fsm #(
        .TW         (TW),
        .GAP_TICKS  (GAP_TICKS),
        .ONE_TICKS  (ONE_TICKS),
        .ZERO_TICKS (ZERO_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_zero_i  (len_zero),
        .first_bit_i (frame_data_i[0]),
        .next_bit_i  (next_bit),
        .last_bit_i  (last_bit),
        .tick_i      (tick_en_i),
        .ks_bit_i    (keystream_bit_i),
        .count_i     (count),
        .carrier_o   (carrier_o),
        .advance_o   (keystream_advance_o),
        .done_o      (done_o),
        .load_o      (load),
        .shift_o     (shift),
        .clear_o     (clear)
    );

    AST_ADV_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        keystream_advance_o |-> (carrier_o && !$past(carrier_o))) else $error("advance off rising edge");   // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle");   // R7

    AST_BITS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> left != '0) else $error("shift with no bits left");   // R4

endmodule

// File: tb/tb_pwm_frame_tx.sv
module tb_pwm_frame_tx;
    localparam int MB    = 8;
    localparam int GAP   = 3;
    localparam int ONE   = 9;
    localparam int ZERO  = 6;
    localparam int CW    = $clog2(MB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MB-1:0] data = '0;
    logic [CW-1:0] len = '0;
    logic          tick_en = 1'b1;
    logic          ks_bit;
    logic          adv;
    logic          carrier;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_frame_tx #(.MAX_BITS(MB), .GAP_TICKS(GAP), .ONE_TICKS(ONE), .ZERO_TICKS(ZERO)) dut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .start_i             (start),
        .frame_data_i        (data),
        .frame_len_i         (len),
        .tick_en_i           (tick_en),
        .keystream_bit_i     (ks_bit),
        .keystream_advance_o (adv),
        .carrier_o           (carrier),
        .done_o              (done)
    );

    // Keystream source model: 8-bit LFSR stepping on each strobe.
    function automatic logic [7:0] ks_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    logic [7:0] ks_state;
    always @(posedge clk) begin
        if (!rst_n) ks_state <= 8'hA5;
        else if (adv) ks_state <= ks_step(ks_state);
    end
    assign ks_bit = ks_state[0];

    // Tick pattern driver.
    int tick_mode = 0;
    bit freeze = 1'b0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (freeze) tick_en <= 1'b0;
        else if (tick_mode == 0) tick_en <= 1'b1;
        else tick_en <= (cyc % 3) != 0;
    end

    logic tick_q = 1'b0;
    always @(posedge clk) tick_q <= tick_en;

    // Carrier run-length monitor.
    int arm_seq = 0;
    int seen_seq = 0;
    int lows [0:63];
    int highs [0:63];
    int nlow = 0, nhigh = 0, run = 0, nadv = 0, ndone = 0, adv_bad = 0, done_bad = 0;
    logic prev = 1'b1;
    always @(negedge clk) begin
        if (arm_seq != seen_seq) begin
            seen_seq = arm_seq;
            nlow = 0; nhigh = 0; run = 0; nadv = 0; ndone = 0; adv_bad = 0; done_bad = 0;
        end else begin
            if (tick_q) run = run + 1;
            if (carrier != prev) begin
                if (!prev) begin
                    if (nlow < 64) lows[nlow] = run;
                    nlow = nlow + 1;
                end else if (nlow > 0) begin
                    if (nhigh < 64) highs[nhigh] = run;
                    nhigh = nhigh + 1;
                end
                run = 0;
            end
            if (adv) begin
                nadv = nadv + 1;
                if (!(carrier && !prev)) adv_bad = adv_bad + 1;
            end
            if (done) begin
                ndone = ndone + 1;
                if (!(carrier && !prev)) done_bad = done_bad + 1;
            end
        end
        prev = carrier;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send one frame and compare every run against the model.
    task automatic run_frame(input logic [MB-1:0] d, input int n_req, input int mode,
                             input bit inject, input bit do_freeze);
        int n;
        int waited;
        logic [7:0] ks;
        logic c0;
        n = (n_req > MB) ? MB : n_req;
        tick_mode = mode;
        @(negedge clk);
        arm_seq = arm_seq + 1;
        @(negedge clk);
        ks = ks_state;
        data = d;
        len = CW'(n_req);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        data = ~d;
        len = CW'(1);
        if (inject) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (do_freeze) begin
            freeze = 1'b1;
            repeat (2) @(negedge clk);
            c0 = carrier;
            repeat (10) @(negedge clk);
            // R11: no tick, no carrier movement
            chk(carrier == c0, "R11 carrier frozen", carrier, c0);
            freeze = 1'b0;
        end
        waited = 0;
        while (ndone == 0 && waited < 3000) begin
            @(negedge clk);
            waited = waited + 1;
        end
        chk(ndone != 0, "R7 done seen (watchdog)", ndone, 1);
        repeat (25) @(negedge clk);
        // R7 single done on the closing edge; R8 no second frame
        chk(ndone == 1 && done_bad == 0, "R7 done pulse", ndone, 1);
        chk(nlow == n + 1, "R4 R8 R9 gap count", nlow, n + 1);
        chk(nadv == n && adv_bad == 0, "R5 advance count", nadv, n);
        chk(carrier == 1'b1, "R6 carrier back on", carrier, 1);
        for (int i = 0; i < n && i < nhigh && i < nlow; i++) begin
            int exp_len;
            exp_len = (d[i] ^ ks[0]) ? ONE : ZERO;
            chk(lows[i] == GAP, "R2 bit gap", lows[i], GAP);
            chk(lows[i] + highs[i] == exp_len, "R3 R5 bit length", lows[i] + highs[i], exp_len);
            ks = ks_step(ks);
        end
        if (nlow == n + 1) chk(lows[n] == GAP, "R6 closing gap", lows[n], GAP);
        tick_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(carrier == 1'b1, "R1 carrier idle", carrier, 1);
        chk(done == 1'b0, "R1 done idle", done, 0);
        chk(adv == 1'b0, "R1 advance idle", adv, 0);
        repeat (10) @(negedge clk);
        chk(carrier == 1'b1 && done == 1'b0, "R1 idle hold", carrier, 1);

        // R9 zero-length frame, then every length with several patterns (R4)
        for (int n = 0; n <= MB; n++) begin
            run_frame(8'h00, n, 0, 0, 0);
            run_frame(8'hFF, n, 0, 0, 0);
            run_frame(8'hA6, n, 1, 0, 0);
            run_frame(8'h3C, n, 1, 0, 0);
        end
        // R3 R5 exhaustive data at full length
        for (int v = 0; v < 256; v++) run_frame(MB'(v), MB, 0, 0, 0);
        // R10 lengths above maximum
        for (int n = MB + 1; n < (1 << CW); n++) run_frame(8'h5B, n, 0, 0, 0);
        // R8 start during a frame
        run_frame(8'h96, 6, 0, 1, 0);
        run_frame(8'h01, 2, 1, 1, 0);
        // R11 tick hold mid-frame
        run_frame(8'hC3, 8, 0, 0, 1);
        run_frame(8'h7E, 5, 1, 0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule